// File: doc/BRIEF.md
# External Access Port Router

This block sits between a processor core and its two external bus ports. For every external access it chooses which port carries the transfer. It then drives the device selects and strobes that belong to that access.

Routing is programmable. There are three address spaces, and each one is cut into eight equal sections by the top address bits. A 24-bit routing register, which the core can write, sends each section to port A or to port B.

Alongside the routing, fixed comparators watch for four special addresses:
- a write-only system output latch near the top of Y space;
- a read-only system input latch at the top of X space;
- two Y-space addresses that stand for function calls on a neighbouring processor's host interface: transmit-register write and control/status read.

A read of the system input latch also produces a one-cycle input-ready pulse. This tells the source feeding the latch that it may load the next value.

Every select is decoded combinationally from the address, space code and transfer strobe. External accesses therefore finish with no wait states. Only the routing register and the input-ready pulse are clocked.

Top module: `ext_addr_router`

## Requirements
- R1: After reset the routing register holds all zeros, so every valid access selects port A.
- R2: During a transfer with a valid space code, the routing bit at index space*8 + addr[31:29] picks the port: 0 pulls portACsN low, 1 pulls portBCsN low, and exactly one of the two is low.
- R3: Space code 2'b11 asserts no port select and no device strobe. The codes are 00 program, 01 X, 10 Y.
- R4: While xferStrobeN is high, every active-low select and strobe output is high.
- R5: peerHostSelN is low only during a Y-space transfer whose address equals PEER_TX_ADDR (default 32'hFFFF_FF24) or PEER_STAT_ADDR (default 32'hFFFF_FF08).
- R6: sysOutLatchEnN is low only during a Y-space write (rdWrN = 0) to SYS_OUT_ADDR (default 32'hFFFF_FFFC).
- R7: sysInRdEnN is low only during an X-space read (rdWrN = 1) to SYS_IN_ADDR (default 32'hFFFF_FFFF).
- R8: Each system-input read pulses inputReadyN low for exactly one cycle, in the cycle after its first strobed cycle. The pulse comes once per transfer even when the strobe is held.
- R9: With psrWrEn high, psrWrData loads into the routing register at the next rising clock edge. Routing before that edge still uses the old value.
- R10: Selects follow the address, space and strobe inputs in the same cycle, with no wait-state cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psrWrEn | input | 1 | Load strobe for the routing register |
| psrWrData | input | 24 | New routing register value, one bit per section |
| addr | input | 32 | Access address |
| space | input | 2 | Address-space code |
| rdWrN | input | 1 | 1 = read, 0 = write |
| xferStrobeN | input | 1 | Active-low transfer strobe |
| portACsN | output | 1 | Port A select, active low |
| portBCsN | output | 1 | Port B select, active low |
| peerHostSelN | output | 1 | Neighbour host-interface select, active low |
| sysOutLatchEnN | output | 1 | System output latch write enable, active low |
| sysInRdEnN | output | 1 | System input latch read enable, active low |
| inputReadyN | output | 1 | Input latch free pulse, active low |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, three spaces and eight sections per space, which gives a 24-bit routing register. At these defaults every special address falls in section 7 of its space. The tests therefore cover three kinds of near miss: a special address placed in a different space, a routing bit flip on the section that holds the special addresses, and addresses that differ from a special one by a single word. The held-strobe input read shows that the ready pulse is edge-based rather than level-based.

// File: rtl/ext_router_pkg.sv
package ext_router_pkg;

  typedef enum logic [1:0] {
    SPACE_PROG = 2'b00,
    SPACE_X    = 2'b01,
    SPACE_Y    = 2'b10,
    SPACE_NONE = 2'b11
  } spaceT;

  // Decode results from datapath to control
  typedef struct packed {
    logic spaceValid;
    logic toPortB;
    logic peerHit;
    logic sysOutHit;
    logic sysInHit;
  } decodeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic psrLoad;
  } dpCtrlT;

endpackage

// File: rtl/router_dp.sv
module router_dp
  import ext_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SECT_W = 3,
  parameter int unsigned SPACES = 3,
  parameter logic [ADDR_W-1:0] SYS_IN_ADDR    = 32'hFFFF_FFFF,
  parameter logic [ADDR_W-1:0] SYS_OUT_ADDR   = 32'hFFFF_FFFC,
  parameter logic [ADDR_W-1:0] PEER_TX_ADDR   = 32'hFFFF_FF24,
  parameter logic [ADDR_W-1:0] PEER_STAT_ADDR = 32'hFFFF_FF08,
  localparam int unsigned SECTIONS = 1 << SECT_W,
  localparam int unsigned PSR_W    = SPACES * SECTIONS,
  localparam int unsigned CODE_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            ctrl,
  input  logic [PSR_W-1:0]  psrWrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        space,
  output decodeT            dec
);

  logic [PSR_W-1:0]      psrQ;
  logic [SECT_W-1:0]     section;
  logic [SPACES-1:0]     spaceRoute;
  logic [CODE_SLOTS-1:0] routeBits;
  logic                  isX;
  logic                  isY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psrQ <= '0;
    else if (ctrl.psrLoad) psrQ <= psrWrData;
  end

  assign section = addr[ADDR_W-1 -: SECT_W];

  // One section lookup per address space
  for (genvar g = 0; g < SPACES; g++) begin : gSpace
    assign spaceRoute[g] = psrQ[g*SECTIONS + int'(section)];
  end

  always_comb begin
    routeBits = '0;
    routeBits[SPACES-1:0] = spaceRoute;
  end

  assign isX = (space == SPACE_X);
  assign isY = (space == SPACE_Y);

  always_comb begin
    dec.spaceValid = (int'(space) < SPACES);
    dec.toPortB    = routeBits[space];
    dec.peerHit    = isY && ((addr == PEER_TX_ADDR) || (addr == PEER_STAT_ADDR));
    dec.sysOutHit  = isY && (addr == SYS_OUT_ADDR);
    dec.sysInHit   = isX && (addr == SYS_IN_ADDR);
  end

endmodule

// File: rtl/router_ctrl.sv
module router_ctrl
  import ext_router_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   psrWrEn,
  input  logic   rdWrN,
  input  logic   xferStrobeN,
  input  decodeT dec,
  output dpCtrlT ctrl,
  output logic   portACsN,
  output logic   portBCsN,
  output logic   peerHostSelN,
  output logic   sysOutLatchEnN,
  output logic   sysInRdEnN,
  output logic   inputReadyN
);

  logic active;
  logic sysInRead;
  logic sysInPrev;

  assign ctrl.psrLoad = psrWrEn;
  assign active       = !xferStrobeN && dec.spaceValid;

  assign portACsN       = !(active && !dec.toPortB);
  assign portBCsN       = !(active &&  dec.toPortB);
  assign peerHostSelN   = !(active && dec.peerHit);
  assign sysOutLatchEnN = !(active && dec.sysOutHit && !rdWrN);
  assign sysInRead      =   active && dec.sysInHit  &&  rdWrN;
  assign sysInRdEnN     = !sysInRead;

  // Ready pulse on the first strobed cycle of each input-latch read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysInPrev   <= 1'b0;
      inputReadyN <= 1'b1;
    end else begin
      sysInPrev   <= sysInRead;
      inputReadyN <= !(sysInRead && !sysInPrev);
    end
  end

endmodule

// File: rtl/ext_addr_router.sv
module ext_addr_router
  import ext_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SECT_W = 3,
  parameter int unsigned SPACES = 3,
  parameter logic [ADDR_W-1:0] SYS_IN_ADDR    = 32'hFFFF_FFFF,
  parameter logic [ADDR_W-1:0] SYS_OUT_ADDR   = 32'hFFFF_FFFC,
  parameter logic [ADDR_W-1:0] PEER_TX_ADDR   = 32'hFFFF_FF24,
  parameter logic [ADDR_W-1:0] PEER_STAT_ADDR = 32'hFFFF_FF08,
  localparam int unsigned PSR_W = SPACES * (1 << SECT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psrWrEn,
  input  logic [PSR_W-1:0]  psrWrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        space,
  input  logic              rdWrN,
  input  logic              xferStrobeN,
  output logic              portACsN,
  output logic              portBCsN,
  output logic              peerHostSelN,
  output logic              sysOutLatchEnN,
  output logic              sysInRdEnN,
  output logic              inputReadyN
);

  decodeT dec;
  dpCtrlT ctrl;

  router_dp #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .SPACES(SPACES),
    .SYS_IN_ADDR(SYS_IN_ADDR), .SYS_OUT_ADDR(SYS_OUT_ADDR),
    .PEER_TX_ADDR(PEER_TX_ADDR), .PEER_STAT_ADDR(PEER_STAT_ADDR)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .psrWrData(psrWrData),
    .addr(addr), .space(space), .dec(dec)
  );

  router_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .psrWrEn(psrWrEn), .rdWrN(rdWrN),
    .xferStrobeN(xferStrobeN), .dec(dec), .ctrl(ctrl),
    .portACsN(portACsN), .portBCsN(portBCsN), .peerHostSelN(peerHostSelN),
    .sysOutLatchEnN(sysOutLatchEnN), .sysInRdEnN(sysInRdEnN),
    .inputReadyN(inputReadyN)
  );

endmodule

// File: rtl/ext_addr_router_chk.sv
module ext_addr_router_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] space,
  input logic       rdWrN,
  input logic       xferStrobeN,
  input logic       portACsN,
  input logic       portBCsN,
  input logic       peerHostSelN,
  input logic       sysOutLatchEnN,
  input logic       sysInRdEnN,
  input logic       inputReadyN
);

  // R2
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!xferStrobeN && space != 2'b11) |-> $countones({~portACsN, ~portBCsN}) == 1);

  // R3
  no_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    (space == 2'b11) |-> (portACsN && portBCsN && peerHostSelN && sysOutLatchEnN && sysInRdEnN));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStrobeN |-> (portACsN && portBCsN && peerHostSelN && sysOutLatchEnN && sysInRdEnN));

  // R5
  peer_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    !peerHostSelN |-> (space == 2'b10 && !xferStrobeN));

  // R6
  sys_out_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sysOutLatchEnN |-> (!rdWrN && space == 2'b10));

  // R7
  sys_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sysInRdEnN |-> (rdWrN && space == 2'b01));

  // R8
  ready_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inputReadyN |=> inputReadyN);

  // R8
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inputReadyN |-> $past(!sysInRdEnN));

endmodule

bind ext_addr_router ext_addr_router_chk uChk (
  .clk(clk), .rstN(rstN), .space(space), .rdWrN(rdWrN),
  .xferStrobeN(xferStrobeN), .portACsN(portACsN), .portBCsN(portBCsN),
  .peerHostSelN(peerHostSelN), .sysOutLatchEnN(sysOutLatchEnN),
  .sysInRdEnN(sysInRdEnN), .inputReadyN(inputReadyN)
);

// File: tb/tb_ext_addr_router.sv
module tb_ext_addr_router;

  localparam logic [31:0] SYS_IN   = 32'hFFFF_FFFF;
  localparam logic [31:0] SYS_OUT  = 32'hFFFF_FFFC;
  localparam logic [31:0] PEER_TX  = 32'hFFFF_FF24;
  localparam logic [31:0] PEER_ST  = 32'hFFFF_FF08;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psrWrEn = 1'b0;
  logic [23:0] psrWrData = '0;
  logic [31:0] addr = '0;
  logic [1:0]  space = 2'b00;
  logic        rdWrN = 1'b1;
  logic        xferStrobeN = 1'b1;
  logic        portACsN, portBCsN, peerHostSelN, sysOutLatchEnN, sysInRdEnN, inputReadyN;

  int checks = 0;
  int failures = 0;
  logic [23:0] psrModel = '0;

  always #4 clk = ~clk;

  ext_addr_router dut (
    .clk(clk), .rstN(rstN), .psrWrEn(psrWrEn), .psrWrData(psrWrData),
    .addr(addr), .space(space), .rdWrN(rdWrN), .xferStrobeN(xferStrobeN),
    .portACsN(portACsN), .portBCsN(portBCsN), .peerHostSelN(peerHostSelN),
    .sysOutLatchEnN(sysOutLatchEnN), .sysInRdEnN(sysInRdEnN),
    .inputReadyN(inputReadyN)
  );

  // Expected combinational outputs {A, B, peer, sysOut, sysIn}
  function automatic logic [4:0] model(logic [1:0] sp, logic [31:0] a, logic rd, logic stb);
    logic act;
    logic pb;
    act = !stb && sp != 2'b11;
    pb  = (sp == 2'b11) ? 1'b0 : psrModel[int'(sp)*8 + int'(a[31:29])];
    model = { !(act && !pb), !(act && pb),
              !(act && sp == 2'b10 && (a == PEER_TX || a == PEER_ST)),
              !(act && sp == 2'b10 && a == SYS_OUT && !rd),
              !(act && sp == 2'b01 && a == SYS_IN && rd) };
  endfunction

  task automatic drive(logic [1:0] sp, logic [31:0] a, logic rd, logic stb);
    @(negedge clk);
    space = sp; addr = a; rdWrN = rd; xferStrobeN = stb;
    #1;
  endtask

  task automatic checkOuts(string req);
    logic [4:0] act;
    logic [4:0] exp;
    act = {portACsN, portBCsN, peerHostSelN, sysOutLatchEnN, sysInRdEnN};
    exp = model(space, addr, rdWrN, xferStrobeN);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s space=%0d addr=%h act=%b exp=%b", req, space, addr, act, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic testReset();
    drive(2'b00, 32'h0, 1'b1, 1'b1);
    checkOuts("R4 idle after reset");
    checkBit("R8 ready idle after reset", inputReadyN, 1'b1);
  endtask

  task automatic testDefaultRouting();
    // R1: every space and section goes to port A after reset
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 8; k++) begin
        drive(2'(s), {3'(k), 29'h0123_4560}, 1'b1, 1'b0);
        checkOuts("R1 default port A");
        checkBit("R1 port A low", portACsN, 1'b0);
      end
    end
  endtask

  task automatic testPsrRouting();
    // R9: load on edge; old routing seen before it
    @(negedge clk);
    psrWrEn = 1'b1; psrWrData = 24'hA5_3C_81;
    space = 2'b00; addr = 32'h0000_0010; rdWrN = 1'b0; xferStrobeN = 1'b0;
    #1;
    checkBit("R9 old routing before edge", portACsN, 1'b0);
    @(negedge clk);
    psrWrEn = 1'b0;
    psrModel = 24'hA5_3C_81;
    #1;
    checkOuts("R9 new routing after edge");
    // R2/R10: same-cycle selects over several spaces and sections
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 8; k++) begin
        drive(2'(s), {3'(k), 29'h00AB_CDE0}, 1'(k % 2), 1'b0);
        checkOuts("R2 R10 programmed routing");
      end
    end
  endtask

  task automatic testNoSpace();
    drive(2'b11, SYS_IN, 1'b1, 1'b0);
    checkOuts("R3 space 11 no select");
    drive(2'b11, PEER_TX, 1'b0, 1'b0);
    checkOuts("R3 space 11 peer addr");
  endtask

  task automatic testNoStrobe();
    drive(2'b10, PEER_TX, 1'b0, 1'b1);
    checkOuts("R4 no strobe peer");
    drive(2'b01, SYS_IN, 1'b1, 1'b1);
    checkOuts("R4 no strobe sysIn");
    @(negedge clk); #1;
    checkBit("R4 R8 no ready without strobe", inputReadyN, 1'b1);
  endtask

  task automatic testPeer();
    drive(2'b10, PEER_TX, 1'b0, 1'b0);
    checkOuts("R5 peer tx");
    checkBit("R5 peer tx low", peerHostSelN, 1'b0);
    drive(2'b10, PEER_ST, 1'b1, 1'b0);
    checkOuts("R5 peer status");
    checkBit("R5 peer status low", peerHostSelN, 1'b0);
    drive(2'b10, PEER_TX + 32'd4, 1'b0, 1'b0);
    checkOuts("R5 near miss");
    drive(2'b01, PEER_TX, 1'b0, 1'b0);
    checkOuts("R5 wrong space");
    drive(2'b00, PEER_ST, 1'b1, 1'b0);
    checkOuts("R5 program space");
  endtask

  task automatic testSysOut();
    drive(2'b10, SYS_OUT, 1'b0, 1'b0);
    checkOuts("R6 write");
    checkBit("R6 latch enable low", sysOutLatchEnN, 1'b0);
    drive(2'b10, SYS_OUT, 1'b1, 1'b0);
    checkOuts("R6 read ignored");
    drive(2'b01, SYS_OUT, 1'b0, 1'b0);
    checkOuts("R6 X space ignored");
    drive(2'b10, SYS_OUT - 32'd4, 1'b0, 1'b0);
    checkOuts("R6 neighbour addr");
  endtask

  task automatic testSysIn();
    drive(2'b00, 32'h0, 1'b1, 1'b1);
    // write to input latch address: no enable, no pulse
    drive(2'b01, SYS_IN, 1'b0, 1'b0);
    checkOuts("R7 write ignored");
    @(negedge clk); #1;
    checkBit("R8 no pulse on write", inputReadyN, 1'b1);
    drive(2'b00, 32'h0, 1'b1, 1'b1);
    drive(2'b10, SYS_IN, 1'b1, 1'b0);
    checkOuts("R7 Y space ignored");
    // held-strobe read: enable now, pulse next cycle only
    drive(2'b01, SYS_IN, 1'b1, 1'b0);
    checkOuts("R7 read enable");
    checkBit("R8 no pulse same cycle", inputReadyN, 1'b1);
    @(negedge clk); #1;
    checkBit("R8 pulse low", inputReadyN, 1'b0);
    @(negedge clk); #1;
    checkBit("R8 pulse one cycle", inputReadyN, 1'b1);
    @(negedge clk); #1;
    checkBit("R8 once per transfer", inputReadyN, 1'b1);
    // back-to-back transfer gives a new pulse
    drive(2'b00, 32'h0, 1'b1, 1'b1);
    drive(2'b01, SYS_IN, 1'b1, 1'b0);
    @(negedge clk); #1;
    checkBit("R8 second pulse", inputReadyN, 1'b0);
    drive(2'b00, 32'h0, 1'b1, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDefaultRouting();
    testPsrRouting();
    testNoSpace();
    testNoStrobe();
    testPeer();
    testSysOut();
    testSysIn();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule